// File: doc/BRIEF.md
# Parallel Link Control Symbol Decoder

This block sits behind the word-alignment logic of a parallel point-to-point link receiver. Each cycle it may accept one 32-bit word, a valid strobe and the framing bit. The framing bit is non-return-to-zero and changes level at the first word of every packet and of every control symbol. A valid word whose framing bit differs from the last accepted value is a start word. A valid word with an unchanged framing bit continues the packet already in progress.

A start word with its top bit set is a control symbol. A start word with its top bit clear opens a new packet. A control symbol has 16 bits of content in the upper half of the word and the bitwise complement of that content in the lower half. The decoder checks the two halves against each other and checks that the symbol type is one of the defined codes. If both checks pass, it issues the type, the acknowledge ID and the receiver buffer status. If either check fails, it raises an error pulse instead. Symbols embedded inside a packet are decoded the same way and do not disturb the packet around them. All results are registered and appear one cycle after the word is accepted.

Top module: `lnk_sym_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `sym_vld`, `pkt_start` and `err_pulse` are low. Reset sets the stored framing level to 0, so a first valid word with `in_frame` = 0 is a continuation word and produces no output.
- R2: A start word with bit 31 = 1, `in_word[15:0]` equal to the inverse of `in_word[31:16]` and a legal type gives `sym_vld` high for one cycle, one cycle later. The fields are: type = bits 30:28, ack ID = bits 27:25, buffer status = bits 21:17. The legal type codes are 0 accepted, 1 retry, 2 not-accepted, 4 idle, 5 link-request and 6 link-response.
- R3: A start word with bit 31 = 0 gives `pkt_start` high for one cycle, one cycle later, with `sym_vld` and `err_pulse` low.
- R4: A valid word whose framing bit equals the stored level produces no output, whatever it contains, including a well-formed symbol.
- R5: A start word with bit 31 = 1 whose lower half is not the exact complement of its upper half gives `err_pulse` one cycle later and no `sym_vld`.
- R6: A start word with bit 31 = 1, correct halves and type code 3 or 7 gives `err_pulse` one cycle later and no `sym_vld`.
- R7: The stored framing level follows `in_frame` on every valid word, errored words included, and holds while `in_vld` is low. A cycle with `in_vld` low produces no output.
- R8: A control symbol embedded in a packet, with the packet's later words carrying the symbol's framing level, decodes normally. The packet words after it produce no `pkt_start` and no error.
- R9: With the default configuration, nonzero values in the reserved bits 24:22 and bit 16 of a symbol do not change its decoding.
- R10: At most one of `sym_vld`, `pkt_start` and `err_pulse` is high in any cycle. Start words on consecutive cycles each give their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Word strobe |
| in_word | input | 32 | Incoming link word |
| in_frame | input | 1 | NRZ framing bit |
| sym_vld | output | 1 | Decoded symbol strobe |
| sym_type | output | 3 | Decoded symbol type code |
| sym_ackid | output | 3 | Decoded acknowledge ID |
| sym_bufst | output | 5 | Decoded receiver buffer status |
| pkt_start | output | 1 | Packet-start pulse |
| err_pulse | output | 1 | Symbol error pulse |

## Verification
Each result of this block (symbol, packet start or error) is due exactly one rising edge after the word that caused it is presented. A quiet cycle is equally due one edge after a continuation word or an idle cycle. The driver presents a word at a falling edge and queues the expected outcome for that word, including the expectation that nothing happens. The monitor takes one queued item per rising edge, 1 ns after the edge. This pairs every output cycle with exactly the word accepted on the preceding edge, so a result that comes early, late or twice is caught.

// File: rtl/lnk_sym_pkg.sv
`timescale 1ns/1ps
package lnk_sym_pkg;

   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_ACCEPT = 3'd0,
      K_RETRY  = 3'd1,
      K_REFUSE = 3'd2,
      K_IDLE   = 3'd4,
      K_LREQ   = 3'd5,
      K_LRSP   = 3'd6
   } sym_kind_e;

   // True for the six defined type codes; codes 3 and 7 are reserved.
   function automatic logic kind_is_legal(input logic [KIND_W-1:0] k);
      logic ok;
      case (k)
         K_ACCEPT, K_RETRY, K_REFUSE, K_IDLE, K_LREQ, K_LRSP: ok = 1'b1;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/lnk_sym_frame.sv
`timescale 1ns/1ps
module lnk_sym_frame (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  logic in_frame,
   output logic frame_q,
   output logic is_start
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      frame_q <= 1'b0;
      else if (in_vld) frame_q <= in_frame;
   end

   // A level change on the framing bit marks the first word of a unit.
   assign is_start = in_vld & (in_frame ^ frame_q);

   // R7: level held while no word is offered
   p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(frame_q));

   // R7: level follows every accepted word
   p_frame_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (frame_q == $past(in_frame)));

endmodule

// File: rtl/lnk_sym_fields.sv
`timescale 1ns/1ps
module lnk_sym_fields #(
   parameter int SYM_W = 16,
   parameter int ACK_W = 3,
   parameter int RSV_W = 3,
   parameter int BUF_W = 5
) (
   input  logic [SYM_W-1:0]                 content,
   output logic                             s_bit,
   output logic [lnk_sym_pkg::KIND_W-1:0]   kind,
   output logic [ACK_W-1:0]                 ackid,
   output logic [BUF_W-1:0]                 bufst,
   output logic [SYM_W-1:0]                 rsvd_bits
);
   import lnk_sym_pkg::*;

   localparam int KIND_LSB = SYM_W - 1 - KIND_W;
   localparam int ACK_LSB  = KIND_LSB - ACK_W;
   localparam int BUF_LSB  = ACK_LSB - RSV_W - BUF_W;

   function automatic logic [SYM_W-1:0] used_mask();
      logic [SYM_W-1:0] m;
      for (int i = 0; i < SYM_W; i++)
         m[i] = (i >= ACK_LSB) || ((i >= BUF_LSB) && (i < BUF_LSB + BUF_W));
      return m;
   endfunction

   localparam logic [SYM_W-1:0] USED = used_mask();

   assign s_bit     = content[SYM_W-1];
   assign kind      = content[KIND_LSB +: KIND_W];
   assign ackid     = content[ACK_LSB +: ACK_W];
   assign bufst     = content[BUF_LSB +: BUF_W];
   assign rsvd_bits = content & ~USED;

endmodule

// File: rtl/lnk_sym_check.sv
`timescale 1ns/1ps
module lnk_sym_check #(
   parameter int SYM_W      = 16,
   parameter bit CHECK_RSVD = 1'b0
) (
   input  logic [SYM_W-1:0]               hi,
   input  logic [SYM_W-1:0]               lo,
   input  logic [lnk_sym_pkg::KIND_W-1:0] kind,
   input  logic [SYM_W-1:0]               rsvd_bits,
   output logic                           halves_ok,
   output logic                           kind_ok,
   output logic                           rsvd_ok
);
   import lnk_sym_pkg::*;

   // Every bit pair must differ for the repeated-inverted copy to be intact.
   assign halves_ok = &(hi ^ lo);
   assign kind_ok   = kind_is_legal(kind);

   generate
      if (CHECK_RSVD) begin : g_rsvd_strict
         assign rsvd_ok = ~|rsvd_bits;
      end else begin : g_rsvd_lax
         logic unused_rsvd;
         assign unused_rsvd = |rsvd_bits;
         assign rsvd_ok     = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/lnk_sym_decoder.sv
`timescale 1ns/1ps
module lnk_sym_decoder #(
   parameter int SYM_W      = 16,
   parameter int ACK_W      = 3,
   parameter int RSV_W      = 3,
   parameter int BUF_W      = 5,
   parameter bit CHECK_RSVD = 1'b0,
   localparam int WORD_W    = 2 * SYM_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_vld,
   input  logic [WORD_W-1:0]              in_word,
   input  logic                           in_frame,
   output logic                           sym_vld,
   output logic [lnk_sym_pkg::KIND_W-1:0] sym_type,
   output logic [ACK_W-1:0]               sym_ackid,
   output logic [BUF_W-1:0]               sym_bufst,
   output logic                           pkt_start,
   output logic                           err_pulse
);
   import lnk_sym_pkg::*;

   localparam int KIND_LSB_W = WORD_W - 1 - KIND_W;
   localparam int ACK_LSB_W  = KIND_LSB_W - ACK_W;
   localparam int BUF_LSB_W  = ACK_LSB_W - RSV_W - BUF_W;

   generate
      if (SYM_W < 2 + KIND_W + ACK_W + RSV_W + BUF_W) begin : g_bad_width
         $error("lnk_sym_decoder: SYM_W too small for the configured fields");
      end
   endgenerate

   logic [SYM_W-1:0]  hi, lo, rsvd_bits;
   logic              frame_q, is_start, s_bit;
   logic [KIND_W-1:0] kind;
   logic [ACK_W-1:0]  ackid;
   logic [BUF_W-1:0]  bufst;
   logic              halves_ok, kind_ok, rsvd_ok, sym_good;

   assign hi = in_word[WORD_W-1:SYM_W];
   assign lo = in_word[SYM_W-1:0];

   lnk_sym_frame u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .in_frame (in_frame),
      .frame_q  (frame_q),
      .is_start (is_start)
   );

   lnk_sym_fields #(
      .SYM_W (SYM_W), .ACK_W (ACK_W), .RSV_W (RSV_W), .BUF_W (BUF_W)
   ) u_fields (
      .content   (hi),
      .s_bit     (s_bit),
      .kind      (kind),
      .ackid     (ackid),
      .bufst     (bufst),
      .rsvd_bits (rsvd_bits)
   );

   lnk_sym_check #(
      .SYM_W (SYM_W), .CHECK_RSVD (CHECK_RSVD)
   ) u_check (
      .hi        (hi),
      .lo        (lo),
      .kind      (kind),
      .rsvd_bits (rsvd_bits),
      .halves_ok (halves_ok),
      .kind_ok   (kind_ok),
      .rsvd_ok   (rsvd_ok)
   );

   assign sym_good = halves_ok & kind_ok & rsvd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_vld   <= 1'b0;
         pkt_start <= 1'b0;
         err_pulse <= 1'b0;
         sym_type  <= '0;
         sym_ackid <= '0;
         sym_bufst <= '0;
      end else begin
         sym_vld   <= is_start & s_bit & sym_good;
         err_pulse <= is_start & s_bit & ~sym_good;
         pkt_start <= is_start & ~s_bit;
         if (is_start & s_bit & sym_good) begin
            sym_type  <= kind;
            sym_ackid <= ackid;
            sym_bufst <= bufst;
         end
      end
   end

   // R10: results are mutually exclusive
   p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sym_vld, pkt_start, err_pulse}));

   // R4: continuation or idle cycles stay silent
   p_quiet_cont_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_vld && (in_frame != frame_q)) |=> !(sym_vld || pkt_start || err_pulse));

   // R3: packet start follows a start word with the top bit clear
   p_pkt_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (in_frame != frame_q) && !in_word[WORD_W-1]) |=> pkt_start);

   // R5: halves that fail to complement give an error
   p_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (in_frame != frame_q) && in_word[WORD_W-1] &&
       (in_word[WORD_W-1:SYM_W] != ~in_word[SYM_W-1:0])) |=> (err_pulse && !sym_vld));

   // R6: reserved type code gives an error
   p_rsvd_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (in_frame != frame_q) && in_word[WORD_W-1] &&
       (in_word[KIND_LSB_W +: 2] == 2'b11)) |=> err_pulse);

   // R2: issued fields come from the word of the previous cycle
   p_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sym_vld |-> ((sym_type  == $past(in_word[KIND_LSB_W +: KIND_W])) &&
                   (sym_ackid == $past(in_word[ACK_LSB_W +: ACK_W])) &&
                   (sym_bufst == $past(in_word[BUF_LSB_W +: BUF_W]))));

endmodule

// File: tb/sim_lnk_sym_decoder.sv
`timescale 1ns/1ps
module sim_lnk_sym_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_frame = 1'b0;
   logic        sym_vld, pkt_start, err_pulse;
   logic [2:0]  sym_type, sym_ackid;
   logic [4:0]  sym_bufst;

   always #10 clk = ~clk;

   lnk_sym_decoder u0 (
      .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_word (in_word),
      .in_frame (in_frame), .sym_vld (sym_vld), .sym_type (sym_type),
      .sym_ackid (sym_ackid), .sym_bufst (sym_bufst),
      .pkt_start (pkt_start), .err_pulse (err_pulse)
   );

   typedef struct {
      logic       e_sym, e_pkt, e_err;
      logic [2:0] e_type, e_ack;
      logic [4:0] e_buf;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;
   logic tb_frame = 1'b0;
   bit   done = 1'b0;

   function automatic logic [31:0] mk_sym(input logic [2:0] t, input logic [2:0] a,
                                          input logic [4:0] b, input logic [3:0] rsv);
      logic [15:0] c;
      c = {1'b1, t, a, rsv[3:1], b, rsv[0]};
      return {c, ~c};
   endfunction

   // Driver: presents one word per falling edge and queues its expected outcome.
   task automatic drive(input logic v, input logic f, input logic [31:0] w, input string req);
      exp_t e;
      logic start;
      @(negedge clk);
      in_vld = v; in_frame = f; in_word = w;
      e.e_sym = 0; e.e_pkt = 0; e.e_err = 0;
      e.e_type = '0; e.e_ack = '0; e.e_buf = '0; e.req = req;
      start = v && (f != tb_frame);
      if (v) tb_frame = f;
      if (start && w[31]) begin
         if (w[15:0] != ~w[31:16])                  e.e_err = 1;
         else if (w[30:28] == 3 || w[30:28] == 7)   e.e_err = 1;
         else begin
            e.e_sym = 1; e.e_type = w[30:28]; e.e_ack = w[27:25]; e.e_buf = w[21:17];
         end
      end else if (start) e.e_pkt = 1;
      exp_q.push_back(e);
   endtask

   // Monitor: one expected item per rising edge, sampled 1 ns after it.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (sym_vld !== e.e_sym || pkt_start !== e.e_pkt || err_pulse !== e.e_err ||
                (e.e_sym && (sym_type !== e.e_type || sym_ackid !== e.e_ack ||
                             sym_bufst !== e.e_buf))) begin
               bad++;
               $display("FAIL %s: got sym=%b pkt=%b err=%b t=%0d a=%0d b=%0d exp sym=%b pkt=%b err=%b t=%0d a=%0d b=%0d",
                        e.req, sym_vld, pkt_start, err_pulse, sym_type, sym_ackid, sym_bufst,
                        e.e_sym, e.e_pkt, e.e_err, e.e_type, e.e_ack, e.e_buf);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: got running exp finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (sym_vld !== 0 || pkt_start !== 0 || err_pulse !== 0) begin
         bad++;
         $display("FAIL R1: got %b%b%b exp 000 in reset", sym_vld, pkt_start, err_pulse);
      end
      rst_n = 1'b1;
      // R1: stored level is 0 after reset, so frame 0 is a continuation
      drive(1, 0, mk_sym(3'd4, 3'd1, 5'd3, 4'd0), "R1");
      // R3: packet start
      drive(1, 1, 32'h1234_5678, "R3");
      // R4: continuation words, one shaped like a good symbol
      drive(1, 1, 32'hABCD_0000, "R4");
      drive(1, 1, mk_sym(3'd0, 3'd2, 5'd9, 4'd0), "R4");
      // R8: embedded symbol then packet words at the new level
      drive(1, 0, mk_sym(3'd4, 3'd5, 5'd17, 4'd0), "R8");
      drive(1, 0, 32'h0F0F_0F0F, "R8");
      drive(1, 0, 32'h8000_7FFF, "R8");
      // R2: every legal type, back to back (R10)
      drive(1, 1, mk_sym(3'd0, 3'd0, 5'd0,  4'd0), "R2");
      drive(1, 0, mk_sym(3'd1, 3'd7, 5'd31, 4'd0), "R2");
      drive(1, 1, mk_sym(3'd2, 3'd3, 5'd21, 4'd0), "R2");
      drive(1, 0, mk_sym(3'd4, 3'd6, 5'd10, 4'd0), "R10");
      drive(1, 1, mk_sym(3'd5, 3'd1, 5'd1,  4'd0), "R10");
      drive(1, 0, mk_sym(3'd6, 3'd4, 5'd16, 4'd0), "R2");
      // R5: single-bit and whole-half mismatches
      drive(1, 1, mk_sym(3'd0, 3'd2, 5'd5, 4'd0) ^ 32'h0000_0100, "R5");
      drive(1, 0, {mk_sym(3'd1, 3'd2, 5'd5, 4'd0)} & 32'hFFFF_0000, "R5");
      // R7: errored word still moved the level; same level is quiet
      drive(1, 0, mk_sym(3'd1, 3'd2, 5'd5, 4'd0), "R7");
      // R6: reserved types
      drive(1, 1, mk_sym(3'd3, 3'd2, 5'd5, 4'd0), "R6");
      drive(1, 0, mk_sym(3'd7, 3'd0, 5'd0, 4'd0), "R6");
      // R7: idle cycle with toggled level is ignored and does not move the level
      drive(0, 1, mk_sym(3'd4, 3'd0, 5'd0, 4'd0), "R7");
      drive(1, 0, mk_sym(3'd4, 3'd0, 5'd0, 4'd0), "R7");
      drive(1, 1, mk_sym(3'd2, 3'd6, 5'd12, 4'd0), "R7");
      // R9: reserved bits set
      drive(1, 0, mk_sym(3'd0, 3'd5, 5'd27, 4'hF), "R9");
      drive(1, 1, mk_sym(3'd5, 3'd2, 5'd8,  4'h5), "R9");
      // R10: packet start right after a symbol, then a symbol
      drive(1, 0, 32'h7FFF_FFFF, "R10");
      drive(1, 1, mk_sym(3'd1, 3'd3, 5'd2, 4'd0), "R10");
      drive(0, 1, 32'h0, "R10");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule